// File: doc/BRIEF.md
# Oversampled / Clocked Serial Character Receiver

This block recovers characters from a single serial receive line and holds the most recent one in a buffer register that the host reads. A frame is a low start bit, the data bits sent least significant first, an optional parity bit and a high stop bit. There are two timing modes. In asynchronous mode the block is paced by a tick enable that runs at sixteen times the bit rate. A falling line is confirmed half a bit later, and every bit after that is sampled once at its centre. In synchronous mode a bit-rate clock arrives on a separate input, and the line is sampled on each falling edge of that clock.

The host selects the character width (seven, eight or nine bits) and the parity rule. It reads the buffer with a one-cycle strobe. The full flag and the per-character error flags clear on that read. The framing-error indicator is different: it follows the line, and it drops only when the line is back high. The line and the external clock pass through synchronizer stages before use.

Top module: `usart_rx_core`

## Requirements
- R1: After reset rx_full, overrun, parity_err and frame_err are 0, and rd_data and rx_bit9 are 0.
- R2: In asynchronous mode a low line seen on a tick is resampled 8 ticks later. If the line is high again at that point, the receiver returns to idle and no character is produced.
- R3: In asynchronous mode each later bit is sampled once every 16 ticks, data least significant bit first. The width field is fmt=00 for 8 bits, 01 for 7 bits (rd_data[7] reads 0) and 10 for 9 bits; 11 behaves as 00.
- R4: At the stop-bit sample the character is moved to rd_data and rx_full is set. A one-cycle rd_strobe clears rx_full.
- R5: With fmt=10 no parity bit is expected. The ninth data bit appears on rx_bit9 and parity_err stays 0 whatever par_en is.
- R6: With par_en=1 and a 7- or 8-bit width, one parity bit follows the data. The rule is par_sel=00 odd, 01 even, 10 always 1, 11 always 0. A mismatch sets parity_err with the character, and rd_strobe clears it.
- R7: Only one stop bit is checked. A low stop sample raises frame_err and the character is still loaded. frame_err stays high until the line is seen high, and only then does the receiver look for a new start.
- R8: A character that completes while rx_full is set (with no read in the same cycle) sets overrun and replaces rd_data. rd_strobe clears overrun.
- R9: In synchronous mode (sync_mode=1) the line is sampled only on falling edges of sclk. A low sample on such an edge is taken as the start bit, with no half-bit wait, and tick16 is ignored.
- R10: For 7- and 8-bit widths rx_bit9 is loaded as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_mode | input | 1 | 0 = asynchronous oversampled, 1 = synchronous on sclk |
| tick16 | input | 1 | One-cycle enable at 16x bit rate (asynchronous mode) |
| sclk | input | 1 | Bit-rate clock for synchronous mode |
| rxd | input | 1 | Serial receive line, idle high |
| fmt | input | 2 | Character width select |
| par_en | input | 1 | Parity bit present and checked (7/8-bit widths) |
| par_sel | input | 2 | Parity rule select |
| rd_strobe | input | 1 | One-cycle buffer read |
| rd_data | output | 8 | Received character |
| rx_bit9 | output | 1 | Ninth received data bit |
| rx_full | output | 1 | Buffer holds an unread character |
| parity_err | output | 1 | Parity mismatch on the buffered character |
| frame_err | output | 1 | Stop bit was low; held until the line returns high |
| overrun | output | 1 | A character was replaced before being read |

## Verification
A vector table sends frames in every width, with each parity rule. Some vectors carry a correct parity bit and some an inverted one, which separates a misaligned data field, a wrong parity rule and a parity bit mistaken for data. Directed frames cover the rest. A short low pulse tells start qualification apart from a plain edge trigger. A low stop bit followed by a held-low line shows that frame_err follows the line rather than the read. Two unread frames back to back expose the overrun and replacement behaviour. A synchronous frame clocked on sclk shows that sampling happens on the falling edge and that the half-bit wait is skipped.

// File: rtl/usart_rx_pkg.sv
package usart_rx_pkg;
  localparam int DATA_W   = 8;
  localparam int MAX_BITS = DATA_W + 1;
  localparam int TICKS    = 16;
  localparam int HALF     = TICKS / 2;
  localparam int CNT_W    = $clog2(TICKS);
  localparam int IDX_W    = $clog2(MAX_BITS + 1);

  typedef enum logic [1:0] {
    FMT_8 = 2'b00,
    FMT_7 = 2'b01,
    FMT_9 = 2'b10,
    FMT_X = 2'b11
  } fmt_e;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BREAK
  } rx_state_e;

  function automatic logic [IDX_W-1:0] data_bits(input logic [1:0] f);
    case (f)
      FMT_7:   data_bits = IDX_W'(DATA_W - 1);
      FMT_9:   data_bits = IDX_W'(DATA_W + 1);
      default: data_bits = IDX_W'(DATA_W);
    endcase
  endfunction

  function automatic logic parity_used(input logic [1:0] f, input logic pen);
    parity_used = pen && (f != FMT_9);
  endfunction

  // shift register fills from the top: align by width
  function automatic logic [DATA_W-1:0] align_data(input logic [MAX_BITS-1:0] sh,
                                                   input logic [1:0] f);
    case (f)
      FMT_7:   align_data = {1'b0, sh[MAX_BITS-1:2]};
      FMT_9:   align_data = sh[DATA_W-1:0];
      default: align_data = sh[MAX_BITS-1:1];
    endcase
  endfunction

  function automatic logic expect_parity(input logic [DATA_W-1:0] d,
                                         input logic [1:0] sel);
    case (sel)
      2'b00:   expect_parity = ~(^d);
      2'b01:   expect_parity = ^d;
      2'b10:   expect_parity = 1'b1;
      default: expect_parity = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/rx_front.sv
module rx_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_mode,
  input  logic tick16,
  input  logic sclk,
  input  logic rxd,
  output logic line_s,
  output logic sample_tick
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] rxd_sh;
  logic [MSB:0] sclk_sh;
  logic         sclk_d;
  logic         sclk_fall;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rxd_sh  <= '1;
          sclk_sh <= '1;
        end else begin
          rxd_sh  <= rxd;
          sclk_sh <= sclk;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rxd_sh  <= '1;
          sclk_sh <= '1;
        end else begin
          rxd_sh  <= {rxd_sh[MSB-1:0], rxd};
          sclk_sh <= {sclk_sh[MSB-1:0], sclk};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b1;
    else        sclk_d <= sclk_sh[MSB];
  end

  assign line_s      = rxd_sh[MSB];
  assign sclk_fall   = sclk_d & ~sclk_sh[MSB];
  assign sample_tick = sync_mode ? sclk_fall : tick16;
endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
  import usart_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_mode,
  input  logic              sample_tick,
  input  logic              line_s,
  input  logic [1:0]        fmt,
  input  logic              par_en,
  input  logic [1:0]        par_sel,
  output logic              load_evt,
  output logic [DATA_W-1:0] load_data,
  output logic              load_bit9,
  output logic              load_perr,
  output logic              frame_err,
  output logic              mid_hit
);
  rx_state_e            state;
  logic [CNT_W-1:0]     tcnt;
  logic [IDX_W-1:0]     bidx;
  logic [MAX_BITS-1:0]  shreg;
  logic                 par_bit;
  logic [CNT_W-1:0]     target;
  logic                 last_data;

  assign target    = (state == S_START) ? CNT_W'(HALF - 1) : CNT_W'(TICKS - 1);
  assign mid_hit   = sample_tick && (sync_mode || tcnt == target);
  assign last_data = (bidx == data_bits(fmt) - IDX_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      tcnt      <= '0;
      bidx      <= '0;
      shreg     <= '0;
      par_bit   <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      if (sample_tick) tcnt <= mid_hit ? '0 : tcnt + CNT_W'(1);
      case (state)
        S_IDLE: begin
          tcnt <= '0;
          if (sample_tick && !line_s) begin
            bidx  <= '0;
            state <= sync_mode ? S_DATA : S_START;
          end
        end
        S_START: if (mid_hit) begin
          bidx  <= '0;
          state <= line_s ? S_IDLE : S_DATA;
        end
        S_DATA: if (mid_hit) begin
          shreg <= {line_s, shreg[MAX_BITS-1:1]};
          bidx  <= bidx + IDX_W'(1);
          if (last_data) state <= parity_used(fmt, par_en) ? S_PAR : S_STOP;
        end
        S_PAR: if (mid_hit) begin
          par_bit <= line_s;
          state   <= S_STOP;
        end
        S_STOP: if (mid_hit) begin
          if (line_s) state <= S_IDLE;
          else begin
            state     <= S_BREAK;
            frame_err <= 1'b1;
          end
        end
        S_BREAK: if (line_s) begin
          frame_err <= 1'b0;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign load_evt  = (state == S_STOP) && mid_hit;
  assign load_data = align_data(shreg, fmt);
  assign load_bit9 = (fmt == FMT_9) ? shreg[MAX_BITS-1] : 1'b0;
  assign load_perr = parity_used(fmt, par_en) &&
                     (par_bit != expect_parity(load_data, par_sel));
endmodule

// File: rtl/rx_holding.sv
module rx_holding
  import usart_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_bit9,
  input  logic              load_perr,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_bit9,
  output logic              rx_full,
  output logic              parity_err,
  output logic              overrun
);
  logic lost;
  assign lost = load_evt && rx_full && !rd_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data    <= '0;
      rx_bit9    <= 1'b0;
      rx_full    <= 1'b0;
      parity_err <= 1'b0;
      overrun    <= 1'b0;
    end else if (load_evt) begin
      rd_data    <= load_data;
      rx_bit9    <= load_bit9;
      rx_full    <= 1'b1;
      parity_err <= load_perr;
      overrun    <= lost | (overrun & ~rd_strobe);
    end else if (rd_strobe) begin
      rx_full    <= 1'b0;
      parity_err <= 1'b0;
      overrun    <= 1'b0;
    end
  end
endmodule

// File: rtl/usart_rx_core.sv
module usart_rx_core
  import usart_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_mode,
  input  logic              tick16,
  input  logic              sclk,
  input  logic              rxd,
  input  logic [1:0]        fmt,
  input  logic              par_en,
  input  logic [1:0]        par_sel,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_bit9,
  output logic              rx_full,
  output logic              parity_err,
  output logic              frame_err,
  output logic              overrun
);
  logic              line_s;
  logic              sample_tick;
  logic              load_evt;
  logic [DATA_W-1:0] load_data;
  logic              load_bit9;
  logic              load_perr;
  logic              mid_hit;

  rx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .tick16(tick16),
    .sclk(sclk), .rxd(rxd), .line_s(line_s), .sample_tick(sample_tick)
  );

  rx_deframer u_deframer (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .sample_tick(sample_tick),
    .line_s(line_s), .fmt(fmt), .par_en(par_en), .par_sel(par_sel),
    .load_evt(load_evt), .load_data(load_data), .load_bit9(load_bit9),
    .load_perr(load_perr), .frame_err(frame_err), .mid_hit(mid_hit)
  );

  rx_holding u_holding (
    .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .load_data(load_data),
    .load_bit9(load_bit9), .load_perr(load_perr), .rd_strobe(rd_strobe),
    .rd_data(rd_data), .rx_bit9(rx_bit9), .rx_full(rx_full),
    .parity_err(parity_err), .overrun(overrun)
  );
endmodule

// File: rtl/usart_rx_checker.sv
module usart_rx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_strobe,
  input logic       rx_full,
  input logic       overrun,
  input logic       frame_err,
  input logic       parity_err,
  input logic [1:0] fmt,
  input logic       line_s,
  input logic       load_evt,
  input logic       mid_hit
);
  AST_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && !load_evt |=> !rx_full); // R4
  AST_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> rx_full); // R4
  AST_LOAD_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(mid_hit)); // R3
  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_full)); // R8
  AST_FERR_DROP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_err) |-> $past(line_s)); // R7
  AST_FERR_RAISE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> $past(load_evt && !line_s)); // R7
  AST_NINE_NO_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && fmt == 2'b10 |=> !parity_err); // R5
endmodule

bind usart_rx_core usart_rx_checker u_chk (.*);

// File: tb/tb_usart_rx_core.sv
module tb_usart_rx_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_mode = 1'b0, tick16 = 1'b0, sclk = 1'b1, rxd = 1'b1;
  logic [1:0] fmt = 2'b00, par_sel = 2'b00;
  logic par_en = 1'b0, rd_strobe = 1'b0;
  logic [7:0] rd_data;
  logic rx_bit9, rx_full, parity_err, frame_err, overrun;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  usart_rx_core dut (.*);

  // tick every 4 clocks: one bit = 64 clocks
  always @(negedge clk) begin
    cyc <= cyc + 1;
    tick16 <= ((cyc % 4) == 0);
  end

  always @(negedge clk) if (!done && cyc > 150000) begin
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic abit(input logic b);
    rxd = b; wclk(64);
  endtask

  function automatic logic par_of(input logic [8:0] d, input int n, input logic [1:0] sel);
    int ones = 0;
    for (int i = 0; i < n; i++) ones += d[i];
    case (sel)
      2'b00: return (ones % 2) == 0;
      2'b01: return (ones % 2) == 1;
      2'b10: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic send_async(input logic [8:0] d, input int n, input logic hasp,
                            input logic pb, input logic stopb);
    abit(1'b0);
    for (int i = 0; i < n; i++) abit(d[i]);
    if (hasp) abit(pb);
    abit(stopb);
  endtask

  task automatic sbit(input logic b);
    rxd = b; sclk = 1'b1; wclk(8);
    sclk = 1'b0; wclk(8);
  endtask

  task automatic rd_pulse;
    rd_strobe = 1'b1; wclk(1); rd_strobe = 1'b0; wclk(1);
  endtask

  // {flip, par_en, par_sel, fmt, -, data9}
  localparam logic [15:0] VEC [0:6] = '{
    {1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 9'h0A5},
    {1'b0, 1'b1, 2'd1, 2'd1, 1'b0, 9'h055},
    {1'b0, 1'b1, 2'd0, 2'd0, 1'b0, 9'h03C},
    {1'b0, 1'b1, 2'd0, 2'd2, 1'b0, 9'h181},
    {1'b1, 1'b1, 2'd2, 2'd0, 1'b0, 9'h0F0},
    {1'b0, 1'b1, 2'd3, 2'd1, 1'b0, 9'h07E},
    {1'b1, 1'b1, 2'd1, 2'd0, 1'b0, 9'h001}
  };

  initial begin
    wclk(3);
    // R1 reset state
    chk("R1 full", rx_full, 0); chk("R1 ovr", overrun, 0);
    chk("R1 perr", parity_err, 0); chk("R1 ferr", frame_err, 0);
    chk("R1 data", {rx_bit9, rd_data}, 0);
    rst_n = 1'b1; wclk(10);

    for (int v = 0; v < 7; v++) begin
      logic [15:0] e = VEC[v];
      int n = (e[11:10] == 2'd1) ? 7 : (e[11:10] == 2'd2) ? 9 : 8;
      logic hasp = e[14] && e[11:10] != 2'd2;
      logic pb = par_of(e[8:0], n, e[13:12]) ^ e[15];
      logic [7:0] ed = (n == 7) ? {1'b0, e[6:0]} : e[7:0];
      fmt = e[11:10]; par_en = e[14]; par_sel = e[13:12];
      send_async(e[8:0], n, hasp, pb, 1'b1);
      wclk(4);
      chk("R3 data", rd_data, ed);
      chk(n == 9 ? "R5 bit9" : "R10 bit9", rx_bit9, (n == 9) ? e[8] : 1'b0);
      chk(n == 9 ? "R5 perr" : "R6 perr", parity_err, hasp && e[15]);
      chk("R4 full set", rx_full, 1);
      rd_pulse;
      chk("R4 read clears full", rx_full, 0);
      chk("R6 read clears perr", parity_err, 0);
    end

    // R2 short low pulse rejected
    fmt = 2'd0; par_en = 1'b0;
    rxd = 1'b0; wclk(12); rxd = 1'b1; wclk(1200);
    chk("R2 glitch no char", rx_full, 0);
    chk("R2 glitch no ferr", frame_err, 0);
    send_async(9'h0C3, 8, 0, 0, 1'b1); wclk(4);
    chk("R2 next frame data", rd_data, 8'hC3);
    rd_pulse;

    // R7 low stop bit, line held low
    send_async(9'h05A, 8, 0, 0, 1'b0);
    wclk(200);
    chk("R7 ferr high while low", frame_err, 1);
    chk("R7 char still loaded", {rx_full, rd_data}, {8'h01, 8'h5A});
    rxd = 1'b1; wclk(8);
    chk("R7 ferr drops on high", frame_err, 0);
    rd_pulse;
    wclk(64);
    send_async(9'h011, 8, 0, 0, 1'b1); wclk(4);
    chk("R7 resumes after break", rd_data, 8'h11);
    rd_pulse;

    // R8 overrun, back-to-back with single stop bit
    send_async(9'h0AA, 8, 0, 0, 1'b1);
    send_async(9'h0BB, 8, 0, 0, 1'b1); wclk(4);
    chk("R8 overrun set", overrun, 1);
    chk("R8 data replaced", rd_data, 8'hBB);
    rd_pulse;
    chk("R8 overrun cleared", overrun, 0);
    chk("R4 full cleared", rx_full, 0);

    // R9 synchronous mode on sclk falling edges
    sync_mode = 1'b1; fmt = 2'd0; par_en = 1'b1; par_sel = 2'd1;
    sbit(1'b1); sbit(1'b1);
    begin
      logic [7:0] sd = 8'h96;
      sbit(1'b0);
      for (int i = 0; i < 8; i++) sbit(sd[i]);
      sbit(^sd);
      sbit(1'b1);
    end
    sbit(1'b1); wclk(4);
    chk("R9 sync data", rd_data, 8'h96);
    chk("R9 sync full", rx_full, 1);
    chk("R9 sync perr", parity_err, 0);
    rd_pulse;
    // R9 tick16 ignored: async-style frame without sclk edges
    sclk = 1'b1;
    send_async(9'h0F0, 8, 1, 0, 1'b1); wclk(4);
    chk("R9 tick16 ignored", rx_full, 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule